// File: doc/BRIEF.md
# Periodic Signal Statistics Monitor

This block watches a multi-channel stream of signed samples and condenses each channel into one statistic per measurement window. A down counter sets the window length in clock cycles; when a window closes, the statistic chosen by the mode input is written into a per-channel holding register, and a one-cycle strobe marks the update. A host or a gain-control loop reads the held word at any time. The held word keeps its value until the next window closes.

Three statistics are on offer: the largest sample magnitude, the mean of the squared magnitudes, and the number of samples whose magnitude is above a programmed level. All three are gathered at once during every window. The mode value present in the closing cycle decides which one is kept. A fourth mode value freezes the held word. A single-cycle sync input throws away the window in progress and starts a new one, so that a measurement can be lined up with an external event. Every channel shares one window counter and one mode.

Top module: `sig_stat_monitor`

## Requirements
- R1: While `rst_n` is low, `result_word` and `result_vld` are 0. The first clock edge with `rst_n` high discards its sample and starts the first window, so the first window ends on the edge that falls P+1 edges after reset release.
- R2: The window length P is `win_len`, or 128 when `win_len` is below 128. It is sampled on the edge that starts a window and holds for that whole window. A window covers the samples of exactly P consecutive edges, and windows follow one another with no gap.
- R3: Peak mode (`stat_mode` = 2'b00): on the edge that ends a window, each channel's field becomes the largest magnitude |s| among the window's samples, zero-extended. `result_vld` is high for the cycle after that edge. The sample -2048 gives magnitude 2048.
- R4: Mean-square mode (`stat_mode` = 2'b01): each field becomes floor(sum of s² over the window / P) shifted right by 3 and held as 20 bits, so a full-scale square (2^22) reads as 2^19. The word and the strobe appear 49 edges after the edge that ends the window.
- R5: Threshold mode (`stat_mode` = 2'b10): each field becomes the number of window samples with |s| strictly greater than `mag_thresh`, saturated at 2^20-1. The timing is the same as in R3.
- R6: Hold mode (`stat_mode` = 2'b11): a closing window neither changes `result_word` nor raises `result_vld`.
- R7: The mode is sampled only in the closing cycle of a window. A mode change inside a window gives the newly selected statistic taken over the full window.
- R8: `win_sync` high in a cycle discards the partial window, including that cycle's sample, and starts a new window of length P on that edge. A sync in the closing cycle suppresses that window's result. A mean-square result already being computed is still delivered.
- R9: `result_vld` never stays high for two cycles in a row, and `result_word` changes only together with a strobe.
- R10: Channel c takes its sample from `smp_in[c*12 +: 12]` as two's complement and writes `result_word[c*20 +: 20]`. Every channel shares the window, the mode and the strobe, and channels do not affect one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_in | input | NUM_CH*SAMPLE_W | One signed sample per channel per cycle |
| stat_mode | input | 2 | Statistic select: 00 peak, 01 mean square, 10 threshold count, 11 hold |
| win_len | input | PERIOD_W | Requested window length in cycles |
| mag_thresh | input | SAMPLE_W | Magnitude level used by threshold mode |
| win_sync | input | 1 | Restart pulse for the window |
| result_word | output | NUM_CH*RESULT_W | Held statistic per channel |
| result_vld | output | 1 | One-cycle strobe on each update |

## Verification
Random samples on both channels check that channels stay separate and that the peak, square-sum and count paths agree with an independent model every cycle. Constant inputs such as -2048 give full-scale results with known values, so they catch sign and magnitude errors. A sample equal to the threshold against one just below it shows whether the comparison is strict. Short and long `win_len` values are measured through the spacing of the strobes, which shows whether the 128 clamp applies. Sync pulses placed mid-window and in the closing cycle, together with mode changes inside a window, show that partial windows are discarded and that the mode is sampled only at the end of a window.

// File: rtl/stat_mon_pkg.sv
// Shared types for the periodic signal statistics monitor.
// Assumes: a 2-bit mode field whose encoding is fixed by the block's interface.
package stat_mon_pkg;

    typedef enum logic [1:0] {
        MODE_PEAK = 2'b00,
        MODE_MSQ  = 2'b01,
        MODE_XCNT = 2'b10,
        MODE_HOLD = 2'b11
    } stat_mode_e;

endpackage

// File: rtl/sm_window_ctrl.sv
// Window controller: a down counter that defines the measurement window.
// It raises win_restart when a window is thrown away (sync, or the counter is
// empty after reset) and win_last in the closing cycle of a full window.
// Assumes: MIN_PERIOD >= 2 and MIN_PERIOD < 2**PERIOD_W.
module sm_window_ctrl #(
    parameter int PERIOD_W   = 24,
    parameter int MIN_PERIOD = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_sync,
    input  logic [PERIOD_W-1:0] win_len,
    output logic                win_restart,
    output logic                win_last,
    output logic [PERIOD_W-1:0] win_cnt,
    output logic [PERIOD_W-1:0] win_size
);

    localparam logic [PERIOD_W-1:0] MIN_LEN = PERIOD_W'(MIN_PERIOD);
    localparam logic [PERIOD_W-1:0] ONE     = PERIOD_W'(1);

    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] len_q;
    logic [PERIOD_W-1:0] eff_len;

    // Clamp the requested length to the minimum window.
    always_comb begin
        eff_len = (win_len < MIN_LEN) ? MIN_LEN : win_len;
    end

    assign win_restart = win_sync || (cnt_q == '0);
    assign win_last    = !win_restart && (cnt_q == ONE);

    // Count down through the window, reloading on restart or on the closing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (win_restart || win_last) begin
            cnt_q <= eff_len;
            len_q <= eff_len;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign win_cnt  = cnt_q;
    assign win_size = len_q;

endmodule

// File: rtl/sm_chan_accum.sv
// Per-channel accumulator: tracks peak magnitude, sum of squared magnitudes and
// count of samples above threshold together, so that any mode can be picked at
// window end. The fin_* outputs include the current cycle's sample.
// Assumes: two's complement samples; clear is high on restart and closing cycles.
module sm_chan_accum #(
    parameter  int SAMPLE_W = 12,
    parameter  int PERIOD_W = 24,
    localparam int ACC_W    = 2 * SAMPLE_W + PERIOD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [SAMPLE_W-1:0] smp,
    input  logic [SAMPLE_W-1:0] thresh,
    output logic [SAMPLE_W-1:0] fin_peak,
    output logic [ACC_W-1:0]    fin_sum,
    output logic [PERIOD_W-1:0] fin_xcnt
);

    localparam int SQ_W = 2 * SAMPLE_W;

    logic [SAMPLE_W-1:0] mag;
    logic [SQ_W-1:0]     sq;
    logic                over;
    logic [SAMPLE_W-1:0] peak_q;
    logic [ACC_W-1:0]    sum_q;
    logic [PERIOD_W-1:0] xcnt_q;

    // Magnitude of the signed sample; the most negative code maps to 2**(SAMPLE_W-1).
    always_comb begin
        mag = smp[SAMPLE_W-1] ? (~smp + 1'b1) : smp;
    end

    // Square and threshold compare on the magnitude.
    always_comb begin
        sq   = SQ_W'(mag) * SQ_W'(mag);
        over = (mag > thresh);
    end

    // Running statistics combined with the current sample.
    always_comb begin
        fin_peak = (mag > peak_q) ? mag : peak_q;
        fin_sum  = sum_q + ACC_W'(sq);
        fin_xcnt = xcnt_q + PERIOD_W'(over);
    end

    // Accumulate, or start from zero when the window is restarted or closed.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            peak_q <= '0;
            sum_q  <= '0;
            xcnt_q <= '0;
        end else begin
            peak_q <= fin_peak;
            sum_q  <= fin_sum;
            xcnt_q <= fin_xcnt;
        end
    end

endmodule

// File: rtl/sm_serial_div.sv
// Serial restoring divider: one quotient bit per cycle, DIVIDEND_W cycles per
// division. done pulses on the edge that produces the final bit, and quotient
// holds until the next start. Only the slice [Q_LSB +: Q_W] is brought out.
// Assumes: divisor is nonzero; start never arrives while busy.
module sm_serial_div #(
    parameter int DIVIDEND_W = 48,
    parameter int DIVISOR_W  = 24,
    parameter int Q_LSB      = 3,
    parameter int Q_W        = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [DIVIDEND_W-1:0] dividend,
    input  logic [DIVISOR_W-1:0]  divisor,
    output logic [Q_W-1:0]        quotient,
    output logic                  busy,
    output logic                  done
);

    localparam int                STEP_W    = $clog2(DIVIDEND_W);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(DIVIDEND_W - 1);

    logic [DIVISOR_W:0]    rem_q;
    logic [DIVIDEND_W-1:0] quo_q;
    logic [DIVISOR_W-1:0]  dsr_q;
    logic [STEP_W-1:0]     step_q;
    logic                  busy_q;
    logic                  done_q;
    logic [DIVISOR_W:0]    shifted;
    logic [DIVISOR_W+1:0]  diff;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        shifted = {rem_q[DIVISOR_W-1:0], quo_q[DIVIDEND_W-1]};
        diff    = {1'b0, shifted} - {2'b00, dsr_q};
    end

    // Load on start, then shift and subtract once per cycle until the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dsr_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dsr_q  <= divisor;
                step_q <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= diff[DIVISOR_W+1] ? shifted : diff[DIVISOR_W:0];
                quo_q  <= {quo_q[DIVIDEND_W-2:0], ~diff[DIVISOR_W+1]};
                step_q <= step_q + 1'b1;
                if (step_q == LAST_STEP) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q[Q_LSB +: Q_W];
    assign busy     = busy_q;
    assign done     = done_q;

endmodule

// File: rtl/sig_stat_monitor.sv
// Periodic signal statistics monitor, top level. One window controller is
// shared by NUM_CH channels. Each channel has an accumulator, a serial divider
// for the mean-square mode and a holding register. Peak and count results are
// latched on the closing edge; mean-square results follow once the divider ends.
// Assumes: RESULT_W >= SAMPLE_W, PERIOD_W >= RESULT_W, MIN_PERIOD > 2*SAMPLE_W+PERIOD_W+1
// (a division always ends before the next window can close).
module sig_stat_monitor
    import stat_mon_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int SAMPLE_W   = 12,
    parameter int PERIOD_W   = 24,
    parameter int MIN_PERIOD = 128,
    parameter int RESULT_W   = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_in,
    input  logic [1:0]                 stat_mode,
    input  logic [PERIOD_W-1:0]        win_len,
    input  logic [SAMPLE_W-1:0]        mag_thresh,
    input  logic                       win_sync,
    output logic [NUM_CH*RESULT_W-1:0] result_word,
    output logic                       result_vld
);

    localparam int ACC_W    = 2 * SAMPLE_W + PERIOD_W;
    localparam int MS_SHIFT = 2 * (SAMPLE_W - 1) - (RESULT_W - 1);
    localparam logic [PERIOD_W-1:0] CNT_CAP = PERIOD_W'({RESULT_W{1'b1}});

    stat_mode_e          mode_e;
    logic                win_restart;
    logic                win_last;
    logic [PERIOD_W-1:0] win_cnt;
    logic [PERIOD_W-1:0] win_size;
    logic                latch_now;
    logic                div_start;
    logic [NUM_CH-1:0]   div_busy;
    logic [NUM_CH-1:0]   div_done;
    logic                vld_q;

    assign mode_e = stat_mode_e'(stat_mode);

    sm_window_ctrl #(
        .PERIOD_W  (PERIOD_W),
        .MIN_PERIOD(MIN_PERIOD)
    ) win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_sync   (win_sync),
        .win_len    (win_len),
        .win_restart(win_restart),
        .win_last   (win_last),
        .win_cnt    (win_cnt),
        .win_size   (win_size)
    );

    // Decide at window close whether to latch directly or start a division.
    always_comb begin
        latch_now = win_last && ((mode_e == MODE_PEAK) || (mode_e == MODE_XCNT));
        div_start = win_last && (mode_e == MODE_MSQ);
    end

    for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
        logic [SAMPLE_W-1:0] fin_peak;
        logic [ACC_W-1:0]    fin_sum;
        logic [PERIOD_W-1:0] fin_xcnt;
        logic [RESULT_W-1:0] ms_val;
        logic [RESULT_W-1:0] cnt_sat;
        logic [RESULT_W-1:0] res_q;

        sm_chan_accum #(
            .SAMPLE_W(SAMPLE_W),
            .PERIOD_W(PERIOD_W)
        ) acc_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (win_restart || win_last),
            .smp     (smp_in[gc*SAMPLE_W +: SAMPLE_W]),
            .thresh  (mag_thresh),
            .fin_peak(fin_peak),
            .fin_sum (fin_sum),
            .fin_xcnt(fin_xcnt)
        );

        sm_serial_div #(
            .DIVIDEND_W(ACC_W),
            .DIVISOR_W (PERIOD_W),
            .Q_LSB     (MS_SHIFT),
            .Q_W       (RESULT_W)
        ) div_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (div_start),
            .dividend(fin_sum),
            .divisor (win_size),
            .quotient(ms_val),
            .busy    (div_busy[gc]),
            .done    (div_done[gc])
        );

        // Saturate the crossing count to the result width.
        always_comb begin
            cnt_sat = (fin_xcnt > CNT_CAP) ? {RESULT_W{1'b1}} : fin_xcnt[RESULT_W-1:0];
        end

        // Holding register: updated only by a direct latch or a finished division.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q <= '0;
            end else if (latch_now) begin
                res_q <= (mode_e == MODE_PEAK) ? RESULT_W'(fin_peak) : cnt_sat;
            end else if (div_done[gc]) begin
                res_q <= ms_val;
            end
        end

        assign result_word[gc*RESULT_W +: RESULT_W] = res_q;
    end

    // One-cycle strobe for every holding-register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= latch_now || div_done[0];
        end
    end

    assign result_vld = vld_q;

endmodule

// File: rtl/sig_stat_monitor_chk.sv
// Assertion checker for the statistics monitor, bound into every instance.
// Assumes: it sees the top's ports and the window and divider handshake nets.
module sig_stat_monitor_chk #(
    parameter int NUM_CH     = 2,
    parameter int PERIOD_W   = 24,
    parameter int MIN_PERIOD = 128,
    parameter int RESULT_W   = 20
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [1:0]                 stat_mode,
    input logic                       win_sync,
    input logic [NUM_CH*RESULT_W-1:0] result_word,
    input logic                       result_vld,
    input logic                       win_last,
    input logic                       win_restart,
    input logic [PERIOD_W-1:0]        win_cnt,
    input logic                       div_start,
    input logic [NUM_CH-1:0]          div_busy,
    input logic [NUM_CH-1:0]          div_done
);

    p_min_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_restart || win_last) |=> (win_cnt >= PERIOD_W'(MIN_PERIOD)));

    p_div_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> (div_busy == '0));

    p_vld_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |-> ($past(win_last) || $past(div_done[0])));

    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_last && (stat_mode == 2'b11)) |=> !result_vld);

    p_sync_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sync && (div_done == '0)) |=> !result_vld);

    p_vld_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |=> !result_vld);

    p_word_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !result_vld |-> $stable(result_word));

    p_done_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (div_done != '0) |-> (div_done == '1));

endmodule

bind sig_stat_monitor sig_stat_monitor_chk #(
    .NUM_CH    (NUM_CH),
    .PERIOD_W  (PERIOD_W),
    .MIN_PERIOD(MIN_PERIOD),
    .RESULT_W  (RESULT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_mode  (stat_mode),
    .win_sync   (win_sync),
    .result_word(result_word),
    .result_vld (result_vld),
    .win_last   (win_last),
    .win_restart(win_restart),
    .win_cnt    (win_cnt),
    .div_start  (div_start),
    .div_busy   (div_busy),
    .div_done   (div_done)
);

// File: tb/sig_stat_monitor_tb_top.sv
// Bench: behavioural per-cycle model compared with the design on every cycle,
// plus targeted checks on known values, strobe spacing and strobe counts.
module sig_stat_monitor_tb_top;

    localparam int NCH    = 2;
    localparam int SW     = 12;
    localparam int PW     = 24;
    localparam int RW     = 20;
    localparam int MINP   = 128;
    localparam int MS_LAT = 2 * SW + PW + 1;
    localparam longint RMAX = (64'd1 << RW) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NCH*SW-1:0] smp_in;
    logic [1:0]        stat_mode;
    logic [PW-1:0]     win_len;
    logic [SW-1:0]     mag_thresh;
    logic              win_sync;
    logic [NCH*RW-1:0] result_word;
    logic              result_vld;

    always #4 clk = ~clk;

    sig_stat_monitor dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_in     (smp_in),
        .stat_mode  (stat_mode),
        .win_len    (win_len),
        .mag_thresh (mag_thresh),
        .win_sync   (win_sync),
        .result_word(result_word),
        .result_vld (result_vld)
    );

    int     checks = 0;
    int     fails  = 0;
    string  cur_req = "R1";
    int     pat = 0;
    int     cval [NCH];

    // Model state.
    longint m_cnt, m_len, cyc;
    longint m_pk [NCH];
    longint m_sum [NCH];
    longint m_ct [NCH];
    longint exp_res [NCH];
    longint pend_val [NCH];
    longint pend_due;
    bit     pend, exp_vld, live;

    // Strobe statistics seen at the ports.
    int     n_vld = 0;
    int     back2back = 0;
    bit     prev_vld = 1'b0;
    longint ncyc = 0, last_vld_at = 0, gap = 0;

    function automatic longint mag_of(int c);
        logic signed [SW-1:0] s;
        s = smp_in[c*SW +: SW];
        return (s < 0) ? -longint'(s) : longint'(s);
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        longint eff;
        if (!rst_n) begin
            m_cnt = 0; m_len = 0; cyc = 0; pend = 0; exp_vld = 0; live = 1;
            for (int c = 0; c < NCH; c++) begin
                exp_res[c] = 0; m_pk[c] = 0; m_sum[c] = 0; m_ct[c] = 0;
            end
        end else begin
            cyc++;
            exp_vld = 0;
            if (pend && cyc == pend_due) begin
                for (int c = 0; c < NCH; c++) exp_res[c] = pend_val[c];
                exp_vld = 1;
                pend = 0;
            end
            eff = (win_len < MINP) ? MINP : longint'(win_len);
            if (win_sync || m_cnt == 0) begin
                for (int c = 0; c < NCH; c++) begin m_pk[c] = 0; m_sum[c] = 0; m_ct[c] = 0; end
                m_cnt = eff; m_len = eff;
            end else if (m_cnt == 1) begin
                for (int c = 0; c < NCH; c++) begin
                    longint mg, fpk, fsum, fct;
                    mg   = mag_of(c);
                    fpk  = (mg > m_pk[c]) ? mg : m_pk[c];
                    fsum = m_sum[c] + mg * mg;
                    fct  = m_ct[c] + ((mg > longint'(mag_thresh)) ? 1 : 0);
                    case (stat_mode)
                        2'b00: begin exp_res[c] = fpk; exp_vld = 1; end
                        2'b01: begin pend_val[c] = ((fsum / m_len) >> 3) & RMAX; pend = 1; pend_due = cyc + MS_LAT; end
                        2'b10: begin exp_res[c] = (fct > RMAX) ? RMAX : fct; exp_vld = 1; end
                        default: ;
                    endcase
                    m_pk[c] = 0; m_sum[c] = 0; m_ct[c] = 0;
                end
                m_cnt = eff; m_len = eff;
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    longint mg;
                    mg = mag_of(c);
                    if (mg > m_pk[c]) m_pk[c] = mg;
                    m_sum[c] += mg * mg;
                    if (mg > longint'(mag_thresh)) m_ct[c]++;
                end
                m_cnt--;
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        bit bad;
        if (live) begin
            bad = (result_vld !== exp_vld);
            for (int c = 0; c < NCH; c++)
                if (result_word[c*RW +: RW] !== RW'(exp_res[c])) bad = 1;
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL %s cycle %0d: vld=%0b exp %0b ch0=%0d exp %0d ch1=%0d exp %0d",
                         cur_req, ncyc, result_vld, exp_vld,
                         result_word[0 +: RW], exp_res[0], result_word[RW +: RW], exp_res[1]);
            end
            if (rst_n && result_vld) begin
                n_vld++;
                if (prev_vld) back2back++;
                gap = ncyc - last_vld_at;
                last_vld_at = ncyc;
            end
            prev_vld = result_vld;
            ncyc++;
        end
    end

    task automatic chk(string req, longint act, longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
            for (int c = 0; c < NCH; c++)
                smp_in[c*SW +: SW] = (pat == 0) ? SW'($urandom) : SW'(cval[c]);
        end
    endtask

    task automatic pulse_sync();
        win_sync = 1'b1;
        step(1);
        win_sync = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL R9 watchdog: run not finished, got cycle %0d expected end before 200000", ncyc);
        summary();
        $finish;
    end

    initial begin
        int n0;
        logic [NCH*RW-1:0] snap;
        rst_n = 1'b0; smp_in = '0; stat_mode = 2'b00; win_len = 150;
        mag_thresh = 1000; win_sync = 1'b0;
        cval[0] = 0; cval[1] = 0;
        repeat (5) @(posedge clk);
        #1;
        chk("R1", result_vld, 0);
        chk("R1", result_word, 0);
        rst_n = 1'b1;
        step(160);
        chk("R1", n_vld, 1);

        // Peak mode on random data, channels independent.
        cur_req = "R10";
        step(500);
        cur_req = "R3";
        pat = 1; cval[0] = -2048; cval[1] = 37;
        step(320);
        chk("R3", result_word[0 +: RW], 2048);
        chk("R3", result_word[RW +: RW], 37);

        // Period clamp and period changes.
        cur_req = "R2"; pat = 0;
        win_len = 5;   step(450); chk("R2", gap, 128);
        win_len = 0;   step(300); chk("R2", gap, 128);
        win_len = 300; step(700); chk("R2", gap, 300);
        win_len = 128;

        // Mean square.
        cur_req = "R4"; stat_mode = 2'b01;
        step(600);
        pat = 1; cval[0] = -2048; cval[1] = 100;
        step(420);
        chk("R4", result_word[0 +: RW], 524288);
        chk("R4", result_word[RW +: RW], 1250);

        // Threshold count; equality does not count.
        cur_req = "R5"; stat_mode = 2'b10; mag_thresh = 99;
        cval[0] = -100; cval[1] = 99;
        step(300);
        chk("R5", result_word[0 +: RW], 128);
        chk("R5", result_word[RW +: RW], 0);
        pat = 0; mag_thresh = 700;
        step(400);

        // Hold mode.
        cur_req = "R6"; stat_mode = 2'b11;
        n0 = n_vld; snap = result_word;
        step(400);
        chk("R6", n_vld - n0, 0);
        chk("R6", result_word, snap);

        // Mode change inside a window.
        cur_req = "R7";
        pulse_sync();
        n0 = n_vld;
        step(100);
        stat_mode = 2'b00;
        step(40);
        chk("R7", n_vld - n0, 1);

        // Sync mid-window and in the closing cycle.
        cur_req = "R8";
        n0 = n_vld;
        for (int i = 0; i < 5; i++) begin
            step(100);
            pulse_sync();
        end
        step(127);
        pulse_sync();
        step(100);
        chk("R8", n_vld - n0, 0);
        stat_mode = 2'b01;
        step(130);
        pulse_sync();
        step(300);

        cur_req = "R9";
        chk("R9", back2back, 0);
        chk("R9", (n_vld > 20) ? 1 : 0, 1);

        summary();
        $finish;
    end

endmodule